// File: doc/BRIEF.md
# SMBus Indexed Register Bank Target

This block is a bus target that holds a bank of byte-wide control registers and exposes all of them as one parallel output vector. A host on a two-wire SMBus reaches the bank with indexed block transfers. A write names a start index and a byte count, then streams that many data bytes into consecutive registers. A read first names the index in a short write phase, then issues a repeated start with the read address. The target answers with a count byte taken from a writable count register, followed by register contents from the index onward.

The clock and data lines are sampled by the system clock. Each line passes through a two-flop synchronizer and a three-sample agreement filter before edge detection. The target never drives either line high. It only requests a low level on the data line, and that request drives an external open-drain pad. A strap input picks one of two device addresses. Two bytes carry fixed identification values, and several indices are reserved and read as zero.

Top module: `smb_index_regbank`

## Requirements
- R1: With `addr_sel_i` low the target answers address byte D0h for writes and D1h for reads (7-bit address 68h). With it high the target answers C0h/C1h (7-bit 60h), and the other pair is refused.
- R2: An address byte that does not match is not acknowledged. Every later byte is also left unacknowledged and has no effect until the next start condition.
- R3: A block write (address, index N, count X, X data bytes) acknowledges each byte and stores the data in registers N through N+X-1. The result appears in `ctrl_o[8*i+7:8*i]` for register i.
- R4: Data bytes sent after the X counted bytes are not acknowledged and are not stored.
- R5: A block read (address with write bit, index N, repeated start, address with read bit) returns first the value of register 8 and then registers N, N+1, and so on. The host acknowledges each byte and leaves the last one unacknowledged.
- R6: Register 8 is writable. A new value written there becomes the count byte of every later read.
- R7: Register 6 reads {REV_ID[3:0], 4'b0001} and register 7 reads DEVICE_ID. Writes to either are acknowledged but change nothing.
- R8: Registers 9, 19, 20 and 21 are reserved. They read 00h and writes to them change nothing.
- R9: Indices 22 and above read 00h, and writes to them change nothing.
- R10: After reset: register 1 = FFh, register 2 = 3Fh, register 4 = 00h, register 5 = 3Ch, register 8 = COUNT_DEFAULT (09h), registers 6/7 as in R7, all others 00h.
- R11: A start or stop condition seen in the middle of a byte abandons that byte. Bytes already completed keep their stored values, and a start always begins a new address phase.
- R12: `sda_pull_low_o` is low whenever the target is idle, including after a stop or a refused address. It only changes after a detected SCL falling edge or a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel_i | input | 1 | Address strap: 0 selects D0h/D1h, 1 selects C0h/C1h |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_low_o | output | 1 | 1 requests the open-drain pad to pull the data line low |
| ctrl_o | output | 8*NUM_REGS | Register contents, register i in bits 8*i+7:8*i |

## Verification
The assertions assume a well-formed host. It changes SDA only while SCL is low, except to form start and stop conditions, and it holds every line level for longer than the synchronizer and filter latency, so that start and stop never coincide with a clock edge event. The bench's bus tasks hold each phase for ten system clocks. They change SDA only a full phase after lowering SCL, which leaves time for the target's own drive changes to settle before the next SCL rise. The aborted-byte and refused-address tests break the byte framing on purpose, but they still form legal start and stop conditions.

// File: rtl/smb_regbank_pkg.sv
package smb_regbank_pkg;

    // Fixed indices whose behaviour other logic depends on
    localparam int IDX_REV_VEND = 6;
    localparam int IDX_DEV      = 7;
    localparam int IDX_COUNT    = 8;
    localparam int IDX_RSV_A    = 9;
    localparam int IDX_RSV_LO   = 19;
    localparam int IDX_RSV_HI   = 21;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_t;

    typedef enum logic [2:0] {
        ST_ADDR,
        ST_INDEX,
        ST_COUNT,
        ST_WDATA,
        ST_RCOUNT,
        ST_RDATA
    } step_t;

    function automatic logic is_writable(int idx);
        return !(idx == IDX_REV_VEND || idx == IDX_DEV || idx == IDX_RSV_A ||
                 (idx >= IDX_RSV_LO && idx <= IDX_RSV_HI));
    endfunction

    function automatic logic [7:0] reg_default(int idx, logic [7:0] cnt_def);
        case (idx)
            1:         return 8'hFF;
            2:         return 8'h3F;
            5:         return 8'h3C;
            IDX_COUNT: return cnt_def;
            default:   return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            hist_q  <= '1;
            level_o <= 1'b1;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            if ((&hist_q) && !level_o) begin
                level_o <= 1'b1;
                rise_o  <= 1'b1;
            end else if (!(|hist_q) && level_o) begin
                level_o <= 1'b0;
                fall_o  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
    import smb_regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rd_data,
    input  logic [7:0] count_val,
    output logic [7:0] rd_idx,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       sda_low
);
    phase_t     phase;
    step_t      step;
    logic [7:0] shreg;
    logic [3:0] bitcnt;
    logic [7:0] index;
    logic [7:0] wr_left;
    logic       host_ack;

    logic start_evt, stop_evt, byte_done;
    assign start_evt = sda_fall && scl_lvl;
    assign stop_evt  = sda_rise && scl_lvl;
    assign byte_done = (phase == PH_RX) && scl_fall && (bitcnt == 4'd8);

    assign wr_en   = byte_done && (step == ST_WDATA) && (wr_left != 8'd0);
    assign wr_idx  = index;
    assign wr_data = shreg;
    assign rd_idx  = index;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            step     <= ST_ADDR;
            shreg    <= '0;
            bitcnt   <= '0;
            index    <= '0;
            wr_left  <= '0;
            host_ack <= 1'b0;
            sda_low  <= 1'b0;
        end else if (start_evt) begin
            phase   <= PH_RX;
            step    <= ST_ADDR;
            bitcnt  <= '0;
            sda_low <= 1'b0;
        end else if (stop_evt) begin
            phase   <= PH_IDLE;
            sda_low <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        phase <= PH_RX_ACK;
                        case (step)
                            ST_ADDR: begin
                                if (shreg[7:1] == dev_addr) begin
                                    sda_low <= 1'b1;
                                    step    <= shreg[0] ? ST_RCOUNT : ST_INDEX;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            ST_INDEX: begin
                                index   <= shreg;
                                sda_low <= 1'b1;
                                step    <= ST_COUNT;
                            end
                            ST_COUNT: begin
                                wr_left <= shreg;
                                sda_low <= 1'b1;
                                step    <= ST_WDATA;
                            end
                            ST_WDATA: begin
                                if (wr_left != 8'd0) begin
                                    index   <= index + 8'd1;
                                    wr_left <= wr_left - 8'd1;
                                    sda_low <= 1'b1;
                                end
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
                PH_RX_ACK: begin
                    if (scl_fall) begin
                        if (step == ST_RCOUNT) begin
                            sda_low <= ~count_val[7];
                            shreg   <= {count_val[6:0], 1'b0};
                            bitcnt  <= 4'd1;
                            phase   <= PH_TX;
                        end else begin
                            sda_low <= 1'b0;
                            bitcnt  <= '0;
                            phase   <= PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_low <= 1'b0;
                            phase   <= PH_TX_ACK;
                        end else begin
                            sda_low <= ~shreg[7];
                            shreg   <= {shreg[6:0], 1'b0};
                            bitcnt  <= bitcnt + 4'd1;
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            sda_low <= ~rd_data[7];
                            shreg   <= {rd_data[6:0], 1'b0};
                            bitcnt  <= 4'd1;
                            index   <= index + 8'd1;
                            step    <= ST_RDATA;
                            phase   <= PH_TX;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R12: released whenever idle
    p_idle_release_r12: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_low);
    // R12: drive moves only after a bus event
    p_drive_on_event_r12: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low) |-> $past(scl_fall || start_evt || stop_evt));
    // R11: stop always returns to idle
    p_stop_idle_r11: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (phase == PH_IDLE));
    // R11: start always opens a fresh address phase
    p_start_addr_r11: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> (phase == PH_RX && step == ST_ADDR && bitcnt == 4'd0));
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_regbank_pkg::*;
#(
    parameter int         NUM_REGS      = 22,
    parameter logic [3:0] REV_ID        = 4'h0,
    parameter logic [7:0] DEVICE_ID     = 8'h2C,
    parameter logic [7:0] COUNT_DEFAULT = 8'h09
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_idx,
    output logic [7:0]            rd_data,
    output logic [7:0]            count_o,
    output logic [8*NUM_REGS-1:0] ctrl_o
);
    localparam logic [7:0] IDX_END = 8'(NUM_REGS);

    logic [7:0] view [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == IDX_REV_VEND) begin : g_rev
            assign view[i] = {REV_ID, 4'b0001};
        end else if (i == IDX_DEV) begin : g_dev
            assign view[i] = DEVICE_ID;
        end else if (!is_writable(i)) begin : g_rsv
            assign view[i] = 8'h00;
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reg_default(i, COUNT_DEFAULT);
                else if (wr_en && wr_idx == 8'(i))
                    q <= wr_data;
            end
            assign view[i] = q;
        end
        assign ctrl_o[8*i +: 8] = view[i];
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == 8'(i)) rd_data = view[i];
    end

    assign count_o = view[IDX_COUNT];

    // R9: out-of-range writes leave the bank untouched
    p_oob_nochange_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= IDX_END) |=> $stable(ctrl_o));
    // R7: identification bytes ignore writes
    p_id_nochange_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_idx == 8'(IDX_REV_VEND) || wr_idx == 8'(IDX_DEV))) |=> $stable(ctrl_o));
endmodule

// File: rtl/smb_index_regbank.sv
module smb_index_regbank #(
    parameter int         NUM_REGS      = 22,
    parameter int         SYNC_STAGES   = 2,
    parameter int         FILT_LEN      = 3,
    parameter logic [6:0] ADDR_PRIMARY  = 7'h68,
    parameter logic [6:0] ADDR_ALT      = 7'h60,
    parameter logic [3:0] REV_ID        = 4'h0,
    parameter logic [7:0] DEVICE_ID     = 8'h2C,
    parameter logic [7:0] COUNT_DEFAULT = 8'h09
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  addr_sel_i,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_low_o,
    output logic [8*NUM_REGS-1:0] ctrl_o
);
    logic [1:0] raw, lvl, rise, fall;
    assign raw = {sda_i, scl_i};

    for (genvar l = 0; l < 2; l++) begin : g_line
        smb_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw[l]),
            .level_o(lvl[l]),
            .rise_o (rise[l]),
            .fall_o (fall[l])
        );
    end

    logic [6:0] dev_addr;
    logic [7:0] rd_idx, rd_data, count_val, wr_idx, wr_data;
    logic       wr_en;

    assign dev_addr = addr_sel_i ? ADDR_ALT : ADDR_PRIMARY;

    smb_target_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .scl_lvl  (lvl[0]),
        .scl_rise (rise[0]),
        .scl_fall (fall[0]),
        .sda_lvl  (lvl[1]),
        .sda_rise (rise[1]),
        .sda_fall (fall[1]),
        .dev_addr (dev_addr),
        .rd_data  (rd_data),
        .count_val(count_val),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_low  (sda_pull_low_o)
    );

    smb_reg_bank #(
        .NUM_REGS     (NUM_REGS),
        .REV_ID       (REV_ID),
        .DEVICE_ID    (DEVICE_ID),
        .COUNT_DEFAULT(COUNT_DEFAULT)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .count_o(count_val),
        .ctrl_o (ctrl_o)
    );
endmodule

// File: tb/tb_smb_index_regbank.sv
`timescale 1ns/1ps
module tb_smb_index_regbank;
    localparam int NREG = 22;
    localparam int Q    = 10;
    localparam logic [7:0] WA0 = 8'hD0;
    localparam logic [7:0] WA1 = 8'hC0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_sel = 1'b0;
    logic scl_drv = 1'b1;
    logic host_rel = 1'b1;
    logic sda_low;
    logic bus_sda;
    logic [8*NREG-1:0] ctrl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    assign bus_sda = host_rel & ~sda_low;

    smb_index_regbank dut (
        .clk           (clk),
        .rst           (rst),
        .addr_sel_i    (addr_sel),
        .scl_i         (scl_drv),
        .sda_i         (bus_sda),
        .sda_pull_low_o(sda_low),
        .ctrl_o        (ctrl)
    );

    // {req, index, write value, expected read}
    localparam logic [31:0] VEC [8] = '{
        {8'd3, 8'h00, 8'h5A, 8'h5A},
        {8'd7, 8'h06, 8'h55, 8'h01},
        {8'd7, 8'h07, 8'h00, 8'h2C},
        {8'd8, 8'h09, 8'hFF, 8'h00},
        {8'd8, 8'h14, 8'hE7, 8'h00},
        {8'd9, 8'h1E, 8'h77, 8'h00},
        {8'd3, 8'h11, 8'hC3, 8'hC3},
        {8'd8, 8'h15, 8'h81, 8'h00}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(int i);
        return ctrl[8*i +: 8];
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_rel = 1'b1; scl_drv = 1'b1; wq();
        host_rel = 1'b0; wq();
        scl_drv = 1'b0;
    endtask

    task automatic bus_rstart();
        wq(); host_rel = 1'b1; wq();
        scl_drv = 1'b1; wq();
        host_rel = 1'b0; wq();
        scl_drv = 1'b0;
    endtask

    task automatic bus_stop();
        wq(); host_rel = 1'b0; wq();
        scl_drv = 1'b1; wq();
        host_rel = 1'b1; wq();
    endtask

    task automatic bus_bit(input logic b, output logic s);
        wq(); host_rel = b; wq();
        scl_drv = 1'b1; wq();
        s = bus_sda;
        scl_drv = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
        bus_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            d[i] = s;
        end
        bus_bit(last, s);
    endtask

    task automatic blk_write(input logic [7:0] wa, input logic [7:0] idx,
                             input logic [7:0] cnt, input logic [31:0] data,
                             input int nsend, output logic [7:0] acks);
        acks = '0;
        bus_start();
        send_byte(wa, acks[0]);
        send_byte(idx, acks[1]);
        send_byte(cnt, acks[2]);
        for (int k = 0; k < nsend; k++) send_byte(data[8*k +: 8], acks[3+k]);
        bus_stop();
    endtask

    task automatic blk_read(input logic [7:0] wa, input logic [7:0] idx,
                            input int nread, output logic [7:0] cnt,
                            output logic [31:0] data, output logic ok);
        logic a0, a1, a2;
        logic [7:0] b;
        data = '0;
        bus_start();
        send_byte(wa, a0);
        send_byte(idx, a1);
        bus_rstart();
        send_byte(wa | 8'h01, a2);
        recv_byte(1'b0, cnt);
        for (int k = 0; k < nread; k++) begin
            recv_byte(k == nread - 1, b);
            data[8*k +: 8] = b;
        end
        bus_stop();
        ok = a0 && a1 && a2;
    endtask

    initial begin : main
        logic [7:0]  acks, cnt;
        logic [31:0] rdata;
        logic        ok, a, s;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset defaults, R7 identification bytes, R12 released
        check("R12", "pull after reset", sda_low, 1'b0);
        check("R10", "reg1", reg_at(1), 8'hFF);
        check("R10", "reg2", reg_at(2), 8'h3F);
        check("R10", "reg4", reg_at(4), 8'h00);
        check("R10", "reg5", reg_at(5), 8'h3C);
        check("R10", "reg8", reg_at(8), 8'h09);
        check("R7", "reg6", reg_at(6), 8'h01);
        check("R7", "reg7", reg_at(7), 8'h2C);

        // Table walk: single-byte write then read-back (R3 R5 R7 R8 R9)
        for (int v = 0; v < 8; v++) begin
            logic [7:0] req, idx, wv, ev;
            {req, idx, wv, ev} = VEC[v];
            blk_write(WA0, idx, 8'd1, {24'h0, wv}, 1, acks);
            check($sformatf("R%0d", req), $sformatf("write acks idx %0h", idx), acks[3:0], 4'hF);
            if (idx < NREG)
                check($sformatf("R%0d", req), $sformatf("ctrl idx %0h", idx), reg_at(int'(idx)), ev);
            blk_read(WA0, idx, 1, cnt, rdata, ok);
            check("R5", "read address acks", ok, 1'b1);
            check("R5", "count byte", cnt, 8'h09);
            check($sformatf("R%0d", req), $sformatf("read idx %0h", idx), rdata[7:0], ev);
        end

        // R3 multi-byte write, R5 auto-increment on read
        blk_write(WA0, 8'h0A, 8'd3, 32'h0033_2211, 3, acks);
        check("R3", "multi acks", acks[5:0], 6'h3F);
        check("R3", "reg10", reg_at(10), 8'h11);
        check("R3", "reg11", reg_at(11), 8'h22);
        check("R3", "reg12", reg_at(12), 8'h33);
        blk_read(WA0, 8'h0A, 4, cnt, rdata, ok);
        check("R5", "stream from 10", rdata, 32'h0033_2211);

        // R9 reading across the end of the bank
        blk_read(WA0, 8'h13, 4, cnt, rdata, ok);
        check("R9", "stream past end", rdata, 32'h0000_0000);

        // R4 extra byte beyond count
        blk_write(WA0, 8'h03, 8'd1, 32'h0000_9944, 2, acks);
        check("R4", "counted byte ack", acks[3], 1'b1);
        check("R4", "extra byte nack", acks[4], 1'b0);
        check("R4", "reg3", reg_at(3), 8'h44);
        check("R4", "reg4 untouched", reg_at(4), 8'h00);

        // R6 count register drives read count byte
        blk_write(WA0, 8'h08, 8'd1, 32'h0000_0005, 1, acks);
        check("R6", "reg8", reg_at(8), 8'h05);
        blk_read(WA0, 8'h00, 1, cnt, rdata, ok);
        check("R6", "count byte after write", cnt, 8'h05);
        check("R5", "reg0 data", rdata[7:0], 8'h5A);

        // R11 stop in the middle of a byte
        bus_start();
        send_byte(WA0, a);
        send_byte(8'h0E, a);
        send_byte(8'h02, a);
        send_byte(8'hA7, a);
        check("R11", "first data ack", a, 1'b1);
        for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
        bus_stop();
        check("R11", "reg14 kept", reg_at(14), 8'hA7);
        check("R11", "reg15 untouched", reg_at(15), 8'h00);
        check("R12", "pull after stop", sda_low, 1'b0);

        // R11 start in the middle of a byte restarts the address phase
        bus_start();
        for (int i = 0; i < 3; i++) bus_bit(1'b1, s);
        bus_rstart();
        send_byte(WA0, a);
        check("R11", "address after restart", a, 1'b1);
        send_byte(8'h10, a);
        send_byte(8'h01, a);
        send_byte(8'h6E, a);
        bus_stop();
        check("R11", "reg16", reg_at(16), 8'h6E);

        // R2 foreign address refused, following bytes ignored
        bus_start();
        send_byte(WA1, a);
        check("R2", "foreign address nack", a, 1'b0);
        send_byte(8'h00, a);
        check("R2", "later byte nack", a, 1'b0);
        send_byte(8'h99, a);
        bus_stop();
        check("R2", "reg0 unchanged", reg_at(0), 8'h5A);
        check("R12", "pull after refusal", sda_low, 1'b0);

        // R1 alternate strap
        addr_sel = 1'b1;
        wq();
        blk_write(WA1, 8'h00, 8'd1, 32'h0000_003C, 1, acks);
        check("R1", "alt address acks", acks[3:0], 4'hF);
        check("R1", "reg0 via alt", reg_at(0), 8'h3C);
        bus_start();
        send_byte(WA0, a);
        bus_stop();
        check("R1", "primary refused under alt strap", a, 1'b0);
        blk_read(WA1, 8'h00, 1, cnt, rdata, ok);
        check("R1", "alt read acks", ok, 1'b1);
        check("R1", "alt read reg0", rdata[7:0], 8'h3C);
        addr_sel = 1'b0;

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule